// File: doc/BRIEF.md
# Delimited Command Frame Parser

This block sits behind a serial receiver and turns a stream of received bytes into decoded command frames. Each byte arrives with a one-cycle valid strobe. A frame opens with the marker byte 0xAA. Next comes a length byte that counts every byte of the frame, both markers included. Then come a command selector byte, an operation code byte, zero to three payload bytes and a closing 0xAA marker. The parser has no knowledge of command meanings. Operations that share an operation code are told apart downstream by the reported length. For example, code 0 with length 5 is a read request with no payload, and code 0 with length 8 carries a device address and two command bytes.

When a well-formed frame closes, the parser pulses a frame-valid strobe for one cycle. At the same edge it publishes the length, command, operation code and payload bytes. These published fields hold until the next well-formed frame. Malformed frames raise a one-cycle error strobe, leave the published fields untouched and send the parser back to hunting for an opening marker. A frame is malformed when its length is out of range, its closing marker is wrong, or the receiver flags an error while the frame is in progress.

Top module: `cfp_parser`

## Requirements
- R1: After reset, both strobes are low and every published field (length, command, operation code, payload) reads zero.
- R2: While hunting for a frame start, any valid byte other than 0xAA is dropped. It causes no strobe and does not start a frame.
- R3: A length byte below 5 or above 8 raises `frm_err` for one cycle, in the cycle after that byte is taken. The parser then hunts again.
- R4: A frame of length L (5..8) whose byte at position L-1 (0-based) is 0xAA raises `frm_vld` in the cycle after that byte is taken. At that point `frm_len`=L, `frm_cmd`=byte 2 and `frm_op`=byte 3. Payload slot k (`frm_payload[8k+7:8k]`) holds byte 4+k when k < L-5, and zero otherwise.
- R5: If the byte at position L-1 is not 0xAA, `frm_err` pulses in the cycle after it and the published fields keep their previous values.
- R6: When `rx_err` is high in any cycle after the opening marker, the frame is aborted and `frm_err` pulses in the next cycle. This holds with or without `rx_vld`, and also when that cycle carries the closing marker. A byte flagged with `rx_err` while hunting is dropped and causes no strobe.
- R7: The published fields change only at the edge that raises `frm_vld`.
- R8: `frm_vld` and `frm_err` are never high together, and each lasts exactly one cycle.
- R9: Cycles with `rx_vld` low and `rx_err` low do not advance the parser, so idle gaps between bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | Byte valid strobe from the receiver |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 1 | Receive error flag from the receiver |
| frm_vld | output | 1 | One-cycle pulse: well-formed frame accepted |
| frm_err | output | 1 | One-cycle pulse: frame discarded as malformed |
| frm_len | output | 8 | Published total frame length |
| frm_cmd | output | 8 | Published command selector |
| frm_op | output | 8 | Published operation code |
| frm_payload | output | 24 | Published payload, slot 0 in bits 7:0 |

## Verification
Two events can land on the same edge: a receive error and the closing byte that would otherwise complete a frame. The bench provokes this by sweeping the error flag across every byte position of a maximum-length frame, including the footer position with a correct 0xAA footer. It expects the error strobe alone and unchanged fields, never the valid strobe. It also raises the error flag with no byte present. Every length value from 0 to 255 and every possible footer value are swept as well, each judged against expectations computed from the frame layout.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_LEN,
    ST_CMD,
    ST_OPC,
    ST_BODY
  } cfp_state_e;
endpackage

// File: rtl/cfp_len_gate.sv
module cfp_len_gate #(
  parameter int DW      = 8,
  parameter int MIN_LEN = 5,
  parameter int MAX_LEN = 8
) (
  input  logic [DW-1:0] len_i,
  output logic          ok_o
);
  assign ok_o = (len_i >= DW'(MIN_LEN)) && (len_i <= DW'(MAX_LEN));
endmodule

// File: rtl/cfp_slot_bank.sv
module cfp_slot_bank #(
  parameter int DW    = 8,
  parameter int SLOTS = 3,
  parameter int IW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                wr_i,
  input  logic [IW-1:0]       idx_i,
  input  logic [DW-1:0]       data_i,
  output logic [SLOTS*DW-1:0] bank_o
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DW-1:0] slot_q, slot_d;
    logic          slot_en;

    assign slot_en = clr_i || (wr_i && (idx_i == IW'(s)));

    always_comb begin
      slot_d = slot_q;
      if (clr_i) slot_d = '0;
      else if (slot_en) slot_d = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else if (slot_en) slot_q <= slot_d;
    end

    assign bank_o[s*DW +: DW] = slot_q;
  end
endmodule

// File: rtl/cfp_parser.sv
module cfp_parser #(
  parameter int          DW      = 8,
  parameter logic [7:0]  MARKER  = 8'hAA,
  parameter int          MIN_LEN = 5,
  parameter int          MAX_LEN = 8,
  parameter int          PRE     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_vld,
  input  logic [DW-1:0]             rx_byte,
  input  logic                      rx_err,
  output logic                      frm_vld,
  output logic                      frm_err,
  output logic [DW-1:0]             frm_len,
  output logic [DW-1:0]             frm_cmd,
  output logic [DW-1:0]             frm_op,
  output logic [(MAX_LEN-PRE-1)*DW-1:0] frm_payload
);
  import cfp_pkg::*;

  localparam int SLOTS = MAX_LEN - PRE - 1;
  localparam int IW    = $clog2(MAX_LEN + 1);
  localparam int PW    = SLOTS * DW;

  cfp_state_e    state_q, state_d;
  logic [IW-1:0] pos_q, pos_d;
  logic [DW-1:0] len_q, len_d, cmd_q, cmd_d, op_q, op_d;
  logic          vld_q, vld_d, err_q, err_d;
  logic [DW-1:0] pub_len_q, pub_cmd_q, pub_op_q;
  logic [PW-1:0] pub_pl_q, work_pl;
  logic          pub_en, pl_clr, pl_wr, len_ok, at_last;
  logic [IW-1:0] slot_idx;

  cfp_len_gate #(.DW(DW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_len_gate (
    .len_i (rx_byte),
    .ok_o  (len_ok)
  );

  assign slot_idx = pos_q - IW'(PRE);
  assign at_last  = (DW'(pos_q) == (len_q - DW'(1)));

  cfp_slot_bank #(.DW(DW), .SLOTS(SLOTS), .IW(IW)) u_slots (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (pl_clr),
    .wr_i   (pl_wr),
    .idx_i  (slot_idx),
    .data_i (rx_byte),
    .bank_o (work_pl)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    len_d   = len_q;
    cmd_d   = cmd_q;
    op_d    = op_q;
    vld_d   = 1'b0;
    err_d   = 1'b0;
    pub_en  = 1'b0;
    pl_clr  = 1'b0;
    pl_wr   = 1'b0;
    if (state_q != ST_HUNT && rx_err) begin
      err_d   = 1'b1;
      state_d = ST_HUNT;
    end else if (rx_vld) begin
      unique case (state_q)
        ST_HUNT: begin
          if (!rx_err && rx_byte == MARKER) begin
            pl_clr  = 1'b1;
            state_d = ST_LEN;
          end
        end
        ST_LEN: begin
          if (len_ok) begin
            len_d   = rx_byte;
            state_d = ST_CMD;
          end else begin
            err_d   = 1'b1;
            state_d = ST_HUNT;
          end
        end
        ST_CMD: begin
          cmd_d   = rx_byte;
          state_d = ST_OPC;
        end
        ST_OPC: begin
          op_d    = rx_byte;
          pos_d   = IW'(PRE);
          state_d = ST_BODY;
        end
        ST_BODY: begin
          if (at_last) begin
            state_d = ST_HUNT;
            if (rx_byte == MARKER) begin
              vld_d  = 1'b1;
              pub_en = 1'b1;
            end else begin
              err_d = 1'b1;
            end
          end else begin
            pl_wr = 1'b1;
            pos_d = pos_q + IW'(1);
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      pos_q   <= '0;
      len_q   <= '0;
      cmd_q   <= '0;
      op_q    <= '0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      len_q   <= len_d;
      cmd_q   <= cmd_d;
      op_q    <= op_d;
      vld_q   <= vld_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pub_len_q <= '0;
      pub_cmd_q <= '0;
      pub_op_q  <= '0;
      pub_pl_q  <= '0;
    end else if (pub_en) begin
      pub_len_q <= len_q;
      pub_cmd_q <= cmd_q;
      pub_op_q  <= op_q;
      pub_pl_q  <= work_pl;
    end
  end

  assign frm_vld     = vld_q;
  assign frm_err     = err_q;
  assign frm_len     = pub_len_q;
  assign frm_cmd     = pub_cmd_q;
  assign frm_op      = pub_op_q;
  assign frm_payload = pub_pl_q;

  // assertions
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_vld && frm_err));
  assert_vld_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |=> !frm_vld);
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |=> !frm_err);
  assert_fields_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld |-> ($stable(frm_len) && $stable(frm_cmd) && $stable(frm_op) && $stable(frm_payload)));
  assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |-> (frm_len >= DW'(MIN_LEN) && frm_len <= DW'(MAX_LEN)));
  assert_hunt_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT && rx_vld && rx_byte != MARKER) |=> (state_q == ST_HUNT && !frm_vld && !frm_err));
  assert_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_HUNT && rx_err) |=> (frm_err && state_q == ST_HUNT));
endmodule

// File: tb/cfp_parser_bench.sv
module cfp_parser_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_vld, rx_err;
  logic [7:0]  rx_byte;
  logic        frm_vld, frm_err;
  logic [7:0]  frm_len, frm_cmd, frm_op;
  logic [23:0] frm_payload;

  int   nchk = 0;
  int   nfail = 0;
  bit   done = 0;
  logic [7:0]  exp_len = '0, exp_cmd = '0, exp_op = '0;
  logic [23:0] exp_pl = '0;

  cfp_parser u_cfp_parser (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte), .rx_err(rx_err),
    .frm_vld(frm_vld), .frm_err(frm_err), .frm_len(frm_len), .frm_cmd(frm_cmd),
    .frm_op(frm_op), .frm_payload(frm_payload)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic e);
    @(negedge clk);
    rx_vld = 1'b1; rx_byte = b; rx_err = e;
    @(negedge clk);
    rx_vld = 1'b0; rx_err = 1'b0;
  endtask

  task automatic chk_strobes(input string tag, input logic v, input logic e);
    chk(frm_vld === v && frm_err === e, tag, {frm_vld, frm_err}, {v, e});
  endtask

  task automatic chk_fields(input string tag);
    chk({frm_len, frm_cmd, frm_op, frm_payload} === {exp_len, exp_cmd, exp_op, exp_pl},
        tag, {frm_len, frm_cmd, frm_op, frm_payload}, {exp_len, exp_cmd, exp_op, exp_pl});
  endtask

  task automatic run_frame(input logic [7:0] len, input logic [7:0] cmd, input logic [7:0] op,
                           input logic [23:0] pl, input logic [7:0] foot, input int errpos, input int gap);
    bit inr = (len >= 5 && len <= 8);
    int n = inr ? int'(len) : 2;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      if (i == 0) b = 8'hAA;
      else if (i == 1) b = len;
      else if (i == 2) b = cmd;
      else if (i == 3) b = op;
      else if (i == n - 1) b = foot;
      else b = pl[(i-4)*8 +: 8];
      repeat (gap) @(negedge clk);
      send(b, i == errpos);
      if (i == errpos) begin
        if (i == 0) chk_strobes("R6 flagged byte while hunting", 1'b0, 1'b0);
        else begin
          chk_strobes("R6 receive error abort", 1'b0, 1'b1);
          chk_fields("R7 fields kept after abort");
        end
        return;
      end
      if (i == 1 && !inr) begin
        chk_strobes("R3 length out of range", 1'b0, 1'b1);
        chk_fields("R7 fields kept after length error");
        return;
      end
      if (i == n - 1) begin
        if (foot == 8'hAA) begin
          exp_len = len; exp_cmd = cmd; exp_op = op;
          exp_pl = '0;
          for (int k = 0; k < 3; k++) if (k < int'(len) - 5) exp_pl[k*8 +: 8] = pl[k*8 +: 8];
          chk_strobes("R4 frame valid strobe", 1'b1, 1'b0);
          chk_fields("R4 published fields");
          @(negedge clk);
          chk_strobes("R8 valid lasts one cycle", 1'b0, 1'b0);
        end else begin
          chk_strobes("R5 bad footer", 1'b0, 1'b1);
          chk_fields("R5 fields kept after bad footer");
          @(negedge clk);
          chk_strobes("R8 error lasts one cycle", 1'b0, 1'b0);
        end
      end else begin
        chk_strobes(gap > 0 ? "R9 mid-frame with gaps" : "R4 no strobe mid-frame", 1'b0, 1'b0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_vld = 1'b0; rx_err = 1'b0; rx_byte = '0;
    repeat (3) @(negedge clk);
    chk_strobes("R1 reset strobes", 1'b0, 1'b0);
    chk_fields("R1 reset fields");
    rst_n = 1'b1;
    @(negedge clk);

    // R2: every non-marker byte while hunting is dropped
    for (int v = 0; v < 256; v++) begin
      if (v == 8'hAA) continue;
      send(8'(v), 1'b0);
      chk_strobes("R2 hunt discards byte", 1'b0, 1'b0);
    end
    run_frame(8'd6, 8'd1, 8'd3, 24'h000001, 8'hAA, 99, 0);

    // R3/R4: sweep of every length byte value
    for (int l = 0; l < 256; l++)
      run_frame(8'(l), 8'(l) ^ 8'h5A, 8'(l % 4), {8'(l), ~8'(l), 8'(l + 1)}, 8'hAA, 99, 0);

    // R5: sweep of every footer value
    for (int f = 0; f < 256; f++)
      run_frame(8'd6, 8'(f), 8'd3, {16'h0, 8'(f)}, 8'(f), 99, 0);

    // read request and transmit-to-device frames
    run_frame(8'd5, 8'd1, 8'd0, 24'hFFFFFF, 8'hAA, 99, 0);
    run_frame(8'd8, 8'd1, 8'd0, 24'h0F3301, 8'hAA, 99, 0);

    // R6: receive error at every position of a full-length frame, incl. footer
    for (int p = 0; p < 8; p++) begin
      run_frame(8'd8, 8'd2, 8'd0, 24'hAA55AA, 8'hAA, p, 0);
      run_frame(8'd7, 8'd1, 8'd4, 24'h000102, 8'hAA, 99, 0);
    end

    // R6: error flag without a byte mid-frame
    send(8'hAA, 1'b0);
    send(8'd7, 1'b0);
    @(negedge clk); rx_err = 1'b1;
    @(negedge clk); rx_err = 1'b0;
    chk_strobes("R6 error flag without byte", 1'b0, 1'b1);
    chk_fields("R7 fields kept after bare error");

    // R9: idle gaps between bytes
    run_frame(8'd8, 8'd9, 8'd0, 24'h123456, 8'hAA, 99, 3);
    run_frame(8'd5, 8'd1, 8'd0, 24'h0, 8'h00, 99, 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule